// File: doc/BRIEF.md
# Threshold Scan Efficiency Sequencer

This block runs a trigger-efficiency sweep over a 10-bit discriminator threshold DAC without software involvement. Once started, it writes a threshold code, waits a programmable number of clock cycles for the DAC output to settle, and then asks an external pulse generator for a fixed burst of test pulses. It uses one request/acknowledge handshake per pulse. While the burst runs, and for a programmable tail after the last pulse, it counts discriminator hits. For each code it presents a result record holding the code, the number of pulses sent and the number of hits seen. The host divides hits by pulses sent to get the efficiency at that threshold, and plots the S-curve from the sweep.

A second mode checks DAC linearity. It ignores the range inputs and visits every code from 0 to the top code in steps of one. At each code it raises a request to an external ADC to sample the DAC output instead of firing pulses. Result records use the same valid/ready handshake, and the sequencer stalls while the consumer holds ready low. A one-cycle done pulse marks the end of a sweep. An abort input brings the sequencer back to idle on the next clock edge.

Top module: `thresh_scan_seq`

## Requirements
- R1: After reset, busy, done, dacLoad, pulseReq, measReq and resValid are all low. A start pulse while idle latches the configuration, puts startCode on dacCode and raises dacLoad for one cycle.
- R2: After every dacLoad cycle, the first pulseReq (threshold mode) or measReq (linearity mode) appears exactly settleCycles+1 cycles later.
- R3: In threshold mode, exactly BURST (100) pulses are accepted per code. pulseReq stays high until pulseAck, each cycle with pulseReq and pulseAck both high is one pulse, and the record's resSent equals 100.
- R4: hitIn is counted once per cycle in which it is high, from the first pulseReq cycle of a code through tailCycles+1 cycles after the cycle of the final accepted pulse. Hits outside that window are not counted.
- R5: The hit count saturates at 255 and does not wrap.
- R6: Codes visited are startCode, startCode+step, and so on, while the code does not exceed stopCode. A stepSize of 0 acts as 1. A startCode above stopCode yields one record at startCode. The code never wraps past 1023.
- R7: While resValid is high and resReady is low, resValid stays high, the record stays unchanged and no new dacLoad occurs.
- R8: done is high for exactly one cycle, the cycle after the last record is accepted, and busy is low in that cycle.
- R9: With linMode high at start, the codes are 0 to 1023 in steps of one, whatever the range inputs. measReq is held until measAck, pulseReq never rises, hitIn is ignored, and each record carries resSent = 0 and resHits = 0.
- R10: In the cycle after abort is high, busy, pulseReq, measReq and resValid are low, and no done pulse follows.
- R11: start and all configuration inputs are ignored while a sweep is running. Only the values latched at start apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep when idle |
| abort | input | 1 | Return to idle on the next edge |
| linMode | input | 1 | Select linearity sweep instead of threshold scan |
| startCode | input | 10 | First threshold code |
| stopCode | input | 10 | Highest code that may be visited |
| stepSize | input | 10 | Code increment (0 treated as 1) |
| settleCycles | input | 16 | DAC settle delay in cycles |
| tailCycles | input | 16 | Hit window extension after the last pulse |
| dacCode | output | 10 | Threshold DAC code |
| dacLoad | output | 1 | One-cycle strobe when dacCode changes |
| pulseReq | output | 1 | Request one test pulse |
| pulseAck | input | 1 | Pulse generator fired the pulse |
| hitIn | input | 1 | Discriminator output |
| measReq | output | 1 | Request an ADC sample of the DAC output |
| measAck | input | 1 | ADC sample taken |
| resValid | output | 1 | Result record valid |
| resReady | input | 1 | Consumer accepts the record |
| resCode | output | 10 | Record: code |
| resSent | output | 7 | Record: pulses sent |
| resHits | output | 8 | Record: hits counted |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit code, a burst of 100 and an 8-bit hit counter. This makes an exhaustive 1024-code linearity sweep affordable. It also lets a hit window of 301 cycles drive the counter past 255, so saturation is reached. Threshold scans run over several ranges, including the top code, a zero step and an inverted range. The pulse generator is modelled with acknowledge latencies of zero and two cycles, and the consumer with a ready that stalls. Expected codes, pulse counts and window-length hit counts are computed arithmetically from the configuration.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_FIRE,
    ST_TAIL,
    ST_MEAS,
    ST_REPORT
  } scanState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchCfg;   // capture configuration and first code
    logic stepCode;   // advance to the next code
    logic clrTimer;   // restart the shared delay timer
    logic countPulse; // one test pulse accepted
    logic windowOpen; // hit window open this cycle
  } scanStrobe_t;

endpackage

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BURST  = 100,
  parameter int HIT_W  = 8,
  parameter int DLY_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  scanStrobe_t               strb,
  input  logic                      linMode,
  input  logic [CODE_W-1:0]         startCode,
  input  logic [CODE_W-1:0]         stopCode,
  input  logic [CODE_W-1:0]         stepSize,
  input  logic [DLY_W-1:0]          settleCycles,
  input  logic [DLY_W-1:0]          tailCycles,
  input  logic                      hitIn,
  output logic [CODE_W-1:0]         curCode,
  output logic [$clog2(BURST+1)-1:0] sentCnt,
  output logic [HIT_W-1:0]          hitCnt,
  output logic                      linActive,
  output logic                      settleDone,
  output logic                      tailDone,
  output logic                      lastPulse,
  output logic                      finalCode
);

  localparam int SENT_W = $clog2(BURST+1);
  localparam logic [HIT_W-1:0]  HIT_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  logic [CODE_W-1:0] cfgStop;
  logic [CODE_W-1:0] cfgStep;
  logic [DLY_W-1:0]  cfgSettle;
  logic [DLY_W-1:0]  cfgTail;
  logic              cfgLin;
  logic [DLY_W-1:0]  timer;
  logic              newCode;

  assign newCode = strb.latchCfg | strb.stepCode;

  // Configuration and code register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgStop   <= '0;
      cfgStep   <= CODE_ONE;
      cfgSettle <= '0;
      cfgTail   <= '0;
      cfgLin    <= 1'b0;
      curCode   <= '0;
    end else if (strb.latchCfg) begin
      cfgStop   <= linMode ? CODE_MAX : stopCode;
      cfgStep   <= (linMode || stepSize == '0) ? CODE_ONE : stepSize;
      cfgSettle <= settleCycles;
      cfgTail   <= tailCycles;
      cfgLin    <= linMode;
      curCode   <= linMode ? '0 : startCode;
    end else if (strb.stepCode) begin
      curCode   <= curCode + cfgStep;
    end
  end

  // Shared delay timer for settle and tail windows
  always_ff @(posedge clk) begin
    if (!rstN)              timer <= '0;
    else if (strb.clrTimer) timer <= '0;
    else if (timer != '1)   timer <= timer + DLY_W'(1);
  end

  // Per-code pulse and hit counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentCnt <= '0;
      hitCnt  <= '0;
    end else if (newCode) begin
      sentCnt <= '0;
      hitCnt  <= '0;
    end else begin
      if (strb.countPulse)
        sentCnt <= sentCnt + SENT_W'(1);
      if (strb.windowOpen && hitIn && hitCnt != HIT_MAX)
        hitCnt <= hitCnt + HIT_W'(1);
    end
  end

  assign linActive  = cfgLin;
  assign settleDone = (timer == cfgSettle);
  assign tailDone   = (timer == cfgTail);
  assign lastPulse  = (sentCnt == SENT_W'(BURST-1));
  assign finalCode  = ({1'b0, curCode} + {1'b0, cfgStep}) > {1'b0, cfgStop};

  // R5: a saturated hit count stays saturated until the next code
  p_hit_saturate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hitCnt == HIT_MAX && !newCode) |=> hitCnt == HIT_MAX);

  // R4: outside the window the hit count does not move
  p_no_hits_outside_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.windowOpen && !newCode) |=> $stable(hitCnt));

  // R3: never more than one burst per code
  p_sent_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt <= SENT_W'(BURST));

  // R6: stepping always moves upward and stays inside the range
  p_code_rises_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepCode |=> (curCode > $past(curCode)) && (curCode <= cfgStop));

endmodule

// File: rtl/scan_control.sv
module scan_control
  import scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        abort,
  input  logic        pulseAck,
  input  logic        measAck,
  input  logic        resReady,
  input  logic        linActive,
  input  logic        settleDone,
  input  logic        tailDone,
  input  logic        lastPulse,
  input  logic        finalCode,
  output scanStrobe_t strb,
  output logic        pulseReq,
  output logic        measReq,
  output logic        resValid,
  output logic        dacLoad,
  output logic        done,
  output logic        busy
);

  scanState_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.latchCfg = 1'b1;
        strb.clrTimer = 1'b1;
        nextState     = ST_SETTLE;
      end
      ST_SETTLE: if (settleDone) begin
        strb.clrTimer = 1'b1;
        nextState     = linActive ? ST_MEAS : ST_FIRE;
      end
      ST_FIRE: begin
        strb.windowOpen = 1'b1;
        if (pulseAck) begin
          strb.countPulse = 1'b1;
          if (lastPulse) begin
            strb.clrTimer = 1'b1;
            nextState     = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        strb.windowOpen = 1'b1;
        if (tailDone) nextState = ST_REPORT;
      end
      ST_MEAS: if (measAck) nextState = ST_REPORT;
      ST_REPORT: if (resReady) begin
        if (finalCode) nextState = ST_IDLE;
        else begin
          strb.stepCode = 1'b1;
          strb.clrTimer = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (abort) begin
      nextState = ST_IDLE;
      strb      = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dacLoad <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= nextState;
      dacLoad <= strb.latchCfg | strb.stepCode;
      done    <= (state == ST_REPORT) && resReady && finalCode && !abort;
    end
  end

  assign pulseReq = (state == ST_FIRE);
  assign measReq  = (state == ST_MEAS);
  assign resValid = (state == ST_REPORT);
  assign busy     = (state != ST_IDLE);

  // R10: abort clears every request on the next edge
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busy && !pulseReq && !measReq && !resValid));

  // R7: an unaccepted record stays presented
  p_hold_record_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady && !abort) |=> resValid);

  // R7: no DAC update while a record is waiting
  p_no_load_in_report_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !dacLoad);

  // R8: done only right after an accepted record
  p_done_follows_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(resValid && resReady) && !busy));

  // R9: linearity mode never requests test pulses
  p_pulse_scan_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    pulseReq |-> !linActive);

endmodule

// File: rtl/thresh_scan_seq.sv
module thresh_scan_seq
  import scan_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BURST  = 100,
  parameter int HIT_W  = 8,
  parameter int DLY_W  = 16,
  localparam int SENT_W = $clog2(BURST+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic              linMode,
  input  logic [CODE_W-1:0] startCode,
  input  logic [CODE_W-1:0] stopCode,
  input  logic [CODE_W-1:0] stepSize,
  input  logic [DLY_W-1:0]  settleCycles,
  input  logic [DLY_W-1:0]  tailCycles,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacLoad,
  output logic              pulseReq,
  input  logic              pulseAck,
  input  logic              hitIn,
  output logic              measReq,
  input  logic              measAck,
  output logic              resValid,
  input  logic              resReady,
  output logic [CODE_W-1:0] resCode,
  output logic [SENT_W-1:0] resSent,
  output logic [HIT_W-1:0]  resHits,
  output logic              busy,
  output logic              done
);

  scanStrobe_t strb;
  logic        linActive, settleDone, tailDone, lastPulse, finalCode;
  logic [CODE_W-1:0] curCode;

  scan_control u_ctrl (
    .clk, .rstN, .start, .abort, .pulseAck, .measAck, .resReady,
    .linActive, .settleDone, .tailDone, .lastPulse, .finalCode,
    .strb, .pulseReq, .measReq, .resValid, .dacLoad, .done, .busy
  );

  scan_datapath #(
    .CODE_W(CODE_W), .BURST(BURST), .HIT_W(HIT_W), .DLY_W(DLY_W)
  ) u_dp (
    .clk, .rstN, .strb, .linMode, .startCode, .stopCode, .stepSize,
    .settleCycles, .tailCycles, .hitIn,
    .curCode, .sentCnt(resSent), .hitCnt(resHits),
    .linActive, .settleDone, .tailDone, .lastPulse, .finalCode
  );

  assign dacCode = curCode;
  assign resCode = curCode;

endmodule

// File: tb/thresh_scan_seq_test.sv
module thresh_scan_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int BURST = 100;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, abort = 0, linMode = 0;
  logic [9:0] startCode = 0, stopCode = 0, stepSize = 0;
  logic [15:0] settleCycles = 0, tailCycles = 0;
  logic [9:0] dacCode, resCode;
  logic dacLoad, pulseReq, pulseAck = 0, hitIn = 0, measReq, measAck = 0;
  logic resValid, resReady = 0, busy, done;
  logic [6:0] resSent;
  logic [7:0] resHits;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  thresh_scan_seq uut (
    .clk, .rstN, .start, .abort, .linMode, .startCode, .stopCode, .stepSize,
    .settleCycles, .tailCycles, .dacCode, .dacLoad, .pulseReq, .pulseAck,
    .hitIn, .measReq, .measAck, .resValid, .resReady, .resCode, .resSent,
    .resHits, .busy, .done
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runScan(input int sc, input int stc, input int stp, input int settle,
                         input int tail, input int k, input int hitMode, input int thr,
                         input int stallN, input bit lin);
    int stepEff, lastCode, expRecs, expCode, recs, age, stallCnt, loadCyc, ackCnt;
    int acceptCyc, expHits, expSent, timeout, prevCode;
    bit waitReq, finalAcc, fin, prevStall;
    stepEff = lin ? 1 : (stp == 0 ? 1 : stp);
    if (lin) lastCode = 1023;
    else begin
      lastCode = sc;
      while (lastCode + stepEff <= stc) lastCode += stepEff;
    end
    expRecs = lin ? 1024 : (lastCode - sc) / stepEff + 1;
    expCode = lin ? 0 : sc;
    recs = 0; age = 0; stallCnt = 0; loadCyc = 0; ackCnt = 0; acceptCyc = 0;
    prevCode = 0; waitReq = 0; finalAcc = 0; fin = 0; prevStall = 0; timeout = 0;
    @(negedge clk);
    startCode = 10'(sc); stopCode = 10'(stc); stepSize = 10'(stp);
    settleCycles = 16'(settle); tailCycles = 16'(tail); linMode = lin; start = 1;
    @(negedge clk);
    // R11: scramble configuration after it is latched
    startCode = 10'((sc + 333) % 1024); stopCode = 0; stepSize = 5; linMode = !lin;
    settleCycles = 16'(settle + 7); tailCycles = 16'(tail + 3);
    while (!fin && timeout < 60000) begin
      timeout++;
      if (timeout == 1)
        chk(dacLoad && busy && dacCode == 10'(expCode), "R1 first load", int'(dacCode), expCode);
      if (dacLoad) begin loadCyc = cyc; waitReq = 1; ackCnt = 0; age = 0; end
      if (waitReq && (pulseReq || measReq)) begin
        chk(cyc - loadCyc == settle + 1, "R2 settle delay", cyc - loadCyc, settle + 1);
        waitReq = 0;
      end
      if (lin && pulseReq) chk(0, "R9 pulseReq in linearity mode", 1, 0);
      if (prevStall)
        chk(resValid && int'(resCode) == prevCode && !dacLoad, "R7 stalled record", int'(resCode), prevCode);
      prevStall = 0;
      if (done) begin
        chk(finalAcc && acceptCyc == cyc - 1 && !busy, "R8 done timing", cyc - acceptCyc, 1);
        fin = 1;
      end else if (finalAcc && cyc > acceptCyc) begin
        chk(0, "R8 done missing", 0, 1);
        fin = 1;
      end
      // drive inputs for the next edge
      start = (timeout == 40 && !fin);   // R11: ignored while busy
      pulseAck = 0; hitIn = 0; measAck = measReq; resReady = 0;
      if (pulseReq) begin
        if (age == k) begin pulseAck = 1; age = 0; ackCnt++; end
        else age++;
      end
      if (hitMode == 1) hitIn = pulseAck && (int'(dacCode) < thr);
      else if (hitMode == 2) hitIn = 1;
      if (resValid && !fin) begin
        if (stallCnt >= stallN) begin
          resReady = 1; stallCnt = 0;
          expSent = lin ? 0 : BURST;
          if (lin || hitMode == 0) expHits = 0;
          else if (hitMode == 1) expHits = (expCode < thr) ? BURST : 0;
          else begin
            expHits = BURST * (k + 1) + tail + 1;
            if (expHits > 255) expHits = 255;
          end
          chk(int'(resCode) == expCode, "R6 record code", int'(resCode), expCode);
          chk(int'(resSent) == expSent, lin ? "R9 sent count" : "R3 sent count", int'(resSent), expSent);
          if (!lin) chk(ackCnt == BURST, "R3 accepted pulses", ackCnt, BURST);
          chk(int'(resHits) == expHits,
              lin ? "R9 hits ignored" : (expHits == 255 ? "R5 saturated hits" : "R4 window hits"),
              int'(resHits), expHits);
          recs++;
          if (recs == expRecs) begin finalAcc = 1; acceptCyc = cyc; end
          else expCode += stepEff;
        end else begin
          stallCnt++; prevStall = 1; prevCode = int'(resCode);
        end
      end
      if (!fin) @(negedge clk);
    end
    chk(fin, "R8 sweep completed", fin, 1);
    chk(recs == expRecs, "R6 record count", recs, expRecs);
    start = 0; resReady = 0; hitIn = 0; pulseAck = 0; measAck = 0;
  endtask

  task automatic runAbort();
    @(negedge clk);
    startCode = 50; stopCode = 60; stepSize = 1; settleCycles = 2; tailCycles = 0;
    linMode = 0; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 20 && !pulseReq; i++) @(negedge clk);
    chk(pulseReq, "R10 reached burst before abort", pulseReq, 1);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(!busy && !pulseReq && !measReq && !resValid, "R10 idle after abort",
        {busy, pulseReq, measReq, resValid}, 0);
    begin
      bit sawDone = 0;
      for (int i = 0; i < 200; i++) begin
        if (done || busy) sawDone = 1;
        @(negedge clk);
      end
      chk(!sawDone, "R10 no done after abort", sawDone, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !done && !dacLoad && !pulseReq && !measReq && !resValid, "R1 reset state",
        {busy, done, dacLoad, pulseReq, measReq, resValid}, 0);
    // S-curve style response, consumer always ready
    runScan(10, 40, 10, 3, 2, 0, 1, 25, 0, 0);
    // top range, slow generator, hits every cycle -> saturation, stalled consumer
    runScan(1000, 1023, 7, 0, 0, 2, 2, 0, 2, 0);
    // zero step, exact window length
    runScan(5, 7, 0, 5, 20, 0, 2, 0, 1, 0);
    // inverted range: single record
    runScan(900, 100, 4, 1, 1, 1, 0, 0, 0, 0);
    // last code exactly at 1023
    runScan(1020, 1023, 3, 2, 4, 0, 1, 1021, 0, 0);
    // abort, then recovery
    runAbort();
    runScan(3, 4, 1, 0, 0, 0, 1, 4, 0, 0);
    // exhaustive linearity sweep with noisy discriminator
    runScan(200, 300, 9, 0, 0, 0, 2, 0, 0, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule